// File: doc/BRIEF.md
# 32-bit Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a classic load/store processor. Each accepted operation carries a 4-bit operation code and two operands. The second operand arrives already shifted, with the shifter's carry-out next to it. The unit returns the result, a destination write-enable and the next N/Z/C/V flags. It also raises two side-band requests. One tells the core to load its status word from the saved copy. The other tells the front end to refetch the instruction stream.

The current flags come in as a 4-bit word and the next flags go out. Flag state therefore stays in the core's status register and not in this unit. When the destination is the program counter (register 15), the flags are not computed. The unit instead copies the top nibble of the saved status word. Whether it asks for a refetch depends on the class of operation. A parameter adds an optional output register. With the default setting, results appear one clock after the operation is presented.

Top module: `dp_alu`

## Requirements
- R1: Operation codes select: 0 AND, 1 XOR, 2 A−B, 3 B−A, 4 A+B, 5 A+B+C, 6 A−B with borrow, 7 B−A with borrow, 8 AND-test, 9 XOR-test, A subtract-compare, B add-compare, C OR, D move B, E A AND NOT B, F NOT B. The result output carries the 32-bit value for every writing code.
- R2: Codes 4, 5 and B add. C is the carry out of bit 31, counting the incoming C for code 5. V is bit 31 of (x^r)&(y^r).
- R3: Codes 2, 3 and A subtract the subtrahend y from the minuend x. Code 3 swaps the operands. C is set when y ≤ x. V is bit 31 of (x^r)&(~y^r).
- R4: Codes 6 and 7 subtract (y − C + 1) from x, evaluated wider than 32 bits. Code 7 swaps the operands. C is set when that subtrahend ≤ x. V follows the R3 formula.
- R5: For logical codes (0, 1, 8, 9, C, D, E, F), N is result bit 31, Z is set for a zero result, C is the shifter carry-out and V keeps its incoming value.
- R6: Codes 8 to B never assert the destination write-enable. They update the flags whether or not set-flags is asserted.
- R7: A writing code with destination 15 and set-flags asserted does the following. It sets the restore request and refetch. It drives the flags from saved-status bits 31:28, which hold N, Z, C and V in that order.
- R8: Any writing code with destination 15 asserts refetch, even with set-flags clear.
- R9: A compare or test code with destination 15 sets the restore request. It takes the flags from the saved status word and leaves refetch low.
- R10: A writing code with set-flags clear returns the incoming flags unchanged.
- R11: With the output register enabled, outputs follow the input by exactly one clock. When no operation is valid, out_valid, write-enable, refetch and restore are all low.
- R12: During and right after reset, out_valid, write-enable, refetch, restore, result and flags are all zero.
- R13: Flags are packed as bit 3 N, bit 2 Z, bit 1 C, bit 0 V on both flag ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Flag update requested |
| dest_idx | input | 4 | Destination register index |
| saved_status | input | 32 | Saved status word |
| out_valid | output | 1 | Result bundle valid |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Destination write-enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| status_restore | output | 1 | Load status word from saved copy |
| refetch | output | 1 | Refetch instruction stream |

## Verification
Every output is registered once, so each result, flag and request belongs to the operation presented on the clock edge before it. The bench drives an operation on a falling edge and records its expected bundle. It compares that bundle against the outputs on the next falling edge, just before driving the following operation. This keeps one operation in flight and aligns each comparison to one clock of latency. Idle cycles are interleaved, and they are checked on that same one-clock schedule to show that the request outputs stay low.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int ALU_DW = 32;
    localparam int ALU_RW = 4;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_XOR = 4'h1, OP_SUB = 4'h2, OP_RSUB = 4'h3,
        OP_ADD = 4'h4, OP_ADDC = 4'h5, OP_SUBC = 4'h6, OP_RSUBC = 4'h7,
        OP_TAND = 4'h8, OP_TXOR = 4'h9, OP_CSUB = 4'hA, OP_CADD = 4'hB,
        OP_OR  = 4'hC, OP_MOVE = 4'hD, OP_CLR = 4'hE, OP_NOT = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic op_is_compare(input alu_op_e op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_logical(input alu_op_e op);
        case (op)
            OP_AND, OP_XOR, OP_TAND, OP_TXOR, OP_OR, OP_MOVE, OP_CLR, OP_NOT:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_add(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_CADD);
    endfunction

    function automatic logic op_swaps(input alu_op_e op);
        return (op == OP_RSUB) || (op == OP_RSUBC);
    endfunction

    function automatic logic op_uses_carry(input alu_op_e op);
        return (op == OP_ADDC) || (op == OP_SUBC) || (op == OP_RSUBC);
    endfunction

endpackage

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
    import dp_alu_pkg::*;
#(
    parameter int DW = ALU_DW
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cin,
    output logic [DW-1:0]    r,
    output logic             c_out,
    output logic             v_out
);
    localparam int WW = DW + 1;

    logic [DW-1:0] x, y;
    logic          ci_eff;
    logic [WW-1:0] add_w, subt_w, diff_w;

    always_comb begin
        x      = op_swaps(op) ? b : a;
        y      = op_swaps(op) ? a : b;
        ci_eff = op_uses_carry(op) ? cin : (op_is_add(op) ? 1'b0 : 1'b1);
        add_w  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci_eff};
        subt_w = {1'b0, y} + {{DW{1'b0}}, ~ci_eff};
        diff_w = {1'b0, x} - subt_w;
        if (op_is_add(op)) begin
            r     = add_w[DW-1:0];
            c_out = add_w[DW];
            v_out = ((x ^ add_w[DW-1:0]) & (y ^ add_w[DW-1:0])) >> (DW-1) != '0;
        end else begin
            r     = diff_w[DW-1:0];
            c_out = subt_w <= {1'b0, x};
            v_out = ((x ^ diff_w[DW-1:0]) & (~y ^ diff_w[DW-1:0])) >> (DW-1) != '0;
        end
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int DW = ALU_DW
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] r
);
    always_comb begin
        case (op)
            OP_AND, OP_TAND: r = a & b;
            OP_XOR, OP_TXOR: r = a ^ b;
            OP_OR:           r = a | b;
            OP_MOVE:         r = b;
            OP_CLR:          r = a & ~b;
            OP_NOT:          r = ~b;
            default:         r = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
    import dp_alu_pkg::*;
#(
    parameter int DW = ALU_DW,
    parameter int RW = ALU_RW
) (
    input  logic          valid,
    input  alu_op_e       op,
    input  logic [DW-1:0] r,
    input  logic          arith_c,
    input  logic          arith_v,
    input  logic          shift_c,
    input  alu_flags_t    fin,
    input  alu_flags_t    saved,
    input  logic          set_flags,
    input  logic [RW-1:0] dest,
    output logic          we,
    output alu_flags_t    fout,
    output logic          restore,
    output logic          refetch
);
    localparam logic [RW-1:0] PC_IDX = RW'((1 << RW) - 1);

    alu_flags_t calc;
    logic       to_pc;

    always_comb begin
        to_pc  = dest == PC_IDX;
        calc.n = r[DW-1];
        calc.z = r == '0;
        calc.c = op_is_logical(op) ? shift_c : arith_c;
        calc.v = op_is_logical(op) ? fin.v   : arith_v;

        we      = 1'b0;
        restore = 1'b0;
        refetch = 1'b0;
        fout    = fin;
        if (valid) begin
            if (op_is_compare(op)) begin
                if (to_pc) begin
                    restore = 1'b1;
                    fout    = saved;
                end else begin
                    fout = calc;
                end
            end else begin
                we      = 1'b1;
                refetch = to_pc;
                if (set_flags) begin
                    if (to_pc) begin
                        restore = 1'b1;
                        fout    = saved;
                    end else begin
                        fout = calc;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dp_alu_stage.sv
module dp_alu_stage #(
    parameter int  W      = 8,
    parameter bit  ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);
    generate
        if (ENABLE) begin : g_reg
            logic         vld_q;
            logic [W-1:0] dat_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else begin
                    vld_q <= vld_i;
                    dat_q <= dat_i;
                end
            end
            assign vld_o = vld_q;
            assign dat_o = dat_q;
        end else begin : g_wire
            assign vld_o = vld_i;
            assign dat_o = dat_i;
        end
    endgenerate
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DW      = ALU_DW,
    parameter int RW      = ALU_RW,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          shift_carry,
    input  logic [3:0]    flags_in,
    input  logic          set_flags,
    input  logic [RW-1:0] dest_idx,
    input  logic [DW-1:0] saved_status,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          dest_we,
    output logic [3:0]    flags_out,
    output logic          status_restore,
    output logic          refetch
);
    typedef struct packed {
        logic [DW-1:0] res;
        logic          we;
        alu_flags_t    fl;
        logic          restore;
        logic          refetch;
    } alu_out_t;

    localparam int BW = $bits(alu_out_t);

    alu_op_e       op;
    logic [DW-1:0] ar_r, lg_r;
    logic          ar_c, ar_v;
    alu_flags_t    fin, saved;
    alu_out_t      nxt, cur;
    logic [BW-1:0] cur_bits;

    assign op    = alu_op_e'(op_code);
    assign fin   = alu_flags_t'(flags_in);
    assign saved = alu_flags_t'(saved_status[DW-1:DW-4]);

    dp_alu_arith #(.DW(DW)) arith_i (
        .op(op), .a(opnd_a), .b(opnd_b), .cin(fin.c),
        .r(ar_r), .c_out(ar_c), .v_out(ar_v)
    );

    dp_alu_logic #(.DW(DW)) logic_i (
        .op(op), .a(opnd_a), .b(opnd_b), .r(lg_r)
    );

    assign nxt.res = op_is_logical(op) ? lg_r : ar_r;

    dp_alu_ctrl #(.DW(DW), .RW(RW)) ctrl_i (
        .valid(in_valid), .op(op), .r(nxt.res), .arith_c(ar_c), .arith_v(ar_v),
        .shift_c(shift_carry), .fin(fin), .saved(saved), .set_flags(set_flags),
        .dest(dest_idx), .we(nxt.we), .fout(nxt.fl), .restore(nxt.restore),
        .refetch(nxt.refetch)
    );

    dp_alu_stage #(.W(BW), .ENABLE(OUT_REG)) stage_i (
        .clk(clk), .rst(rst), .vld_i(in_valid), .dat_i(nxt),
        .vld_o(out_valid), .dat_o(cur_bits)
    );

    assign cur            = alu_out_t'(cur_bits);
    assign result         = cur.res;
    assign dest_we        = cur.we;
    assign flags_out      = cur.fl;
    assign status_restore = cur.restore;
    assign refetch        = cur.refetch;

    AST_REFETCH_WRITES: assert property (@(posedge clk) disable iff (rst)
        refetch |-> dest_we && out_valid);  // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !dest_we && !refetch && !status_restore);  // R11

    generate
        if (OUT_REG) begin : g_chk
            AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
                out_valid && $past(op_code[3:2] == 2'b10) |-> !dest_we && !refetch);  // R6

            AST_RESTORE_SAVED: assert property (@(posedge clk) disable iff (rst)
                out_valid && status_restore |-> flags_out == $past(saved_status[DW-1:DW-4]));  // R7

            AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
                out_valid && !$past(set_flags) && $past(op_code[3:2] != 2'b10)
                |-> flags_out == $past(flags_in));  // R10
        end
    endgenerate
endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic        shift_carry;
    logic [3:0]  flags_in;
    logic        set_flags;
    logic [3:0]  dest_idx;
    logic [31:0] saved_status;
    logic        out_valid;
    logic [31:0] result;
    logic        dest_we;
    logic [3:0]  flags_out;
    logic        status_restore;
    logic        refetch;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dp_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_carry(shift_carry),
        .flags_in(flags_in), .set_flags(set_flags), .dest_idx(dest_idx),
        .saved_status(saved_status), .out_valid(out_valid), .result(result),
        .dest_we(dest_we), .flags_out(flags_out), .status_restore(status_restore),
        .refetch(refetch)
    );

    // expected bundle for the operation in flight
    logic [31:0] e_res;
    logic        e_we, e_rs, e_rf, e_chk_res;
    logic [3:0]  e_fl;
    string       e_tag;

    function automatic string tag_of(input logic [3:0] op, input logic sf, input logic [3:0] d);
        if (d == 4'hF && op[3:2] == 2'b10) return "R9";
        if (d == 4'hF && sf) return "R7";
        if (d == 4'hF) return "R8";
        if (op[3:2] == 2'b10) return "R6";
        if (!sf) return "R10";
        case (op)
            4'h4, 4'h5: return "R2";
            4'h2, 4'h3: return "R3";
            4'h6, 4'h7: return "R4";
            default:    return "R5";
        endcase
    endfunction

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [3:0] fi, input logic sf,
                         input logic [3:0] d, input logic [31:0] sv);
        longint unsigned x, y, s, rr;
        logic [31:0] r;
        logic c, v, lg, cmp;
        int ci;
        ci  = fi[1];
        cmp = op[3:2] == 2'b10;
        lg  = 1'b0;
        c   = 1'b0;
        v   = 1'b0;
        x   = {32'd0, a};
        y   = {32'd0, b};
        if (op == 4'h3 || op == 4'h7) begin x = {32'd0, b}; y = {32'd0, a}; end
        case (op)
            4'h0, 4'h8: begin r = a & b; lg = 1; end
            4'h1, 4'h9: begin r = a ^ b; lg = 1; end
            4'hC: begin r = a | b; lg = 1; end
            4'hD: begin r = b; lg = 1; end
            4'hE: begin r = a & ~b; lg = 1; end
            4'hF: begin r = ~b; lg = 1; end
            4'h4, 4'h5, 4'hB: begin
                rr = x + y + ((op == 4'h5) ? longint'(ci) : 0);
                r  = rr[31:0];
                c  = rr > 64'hFFFF_FFFF;
                v  = ((x[31] ^ r[31]) & (y[31] ^ r[31])) != 0;
            end
            default: begin
                s  = y + (((op == 4'h6) || (op == 4'h7)) ? longint'(1 - ci) : 0);
                rr = x - s;
                r  = rr[31:0];
                c  = s <= x;
                v  = ((x[31] ^ r[31]) & (~y[31] ^ r[31])) != 0;
            end
        endcase
        if (lg) begin c = sc; v = fi[0]; end
        e_res = r; e_chk_res = !cmp; e_we = !cmp;
        e_rf = !cmp && d == 4'hF;
        e_rs = d == 4'hF && (cmp || sf);
        if (e_rs) e_fl = sv[31:28];
        else if (cmp || sf) e_fl = {r[31], r == 0, c, v};
        else e_fl = fi;
        e_tag = tag_of(op, sf, d);
    endtask

    task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_fail++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // drive at a falling edge, compare at the next falling edge (one register stage)
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic [3:0] fi, input logic sf,
                         input logic [3:0] d, input logic [31:0] sv);
        in_valid = 1; op_code = op; opnd_a = a; opnd_b = b; shift_carry = sc;
        flags_in = fi; set_flags = sf; dest_idx = d; saved_status = sv;
        model(op, a, b, sc, fi, sf, d, sv);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b1) fail_line("R11", "out_valid", 32'(out_valid), 32'd1);
        else if (e_chk_res && result !== e_res) fail_line(e_tag == "R10" || e_tag == "R8" || e_tag == "R7" ? "R1" : e_tag, "result", result, e_res);
        else if (dest_we !== e_we) fail_line(e_tag, "dest_we", 32'(dest_we), 32'(e_we));
        else if (flags_out !== e_fl) fail_line(e_tag == "R8" ? "R13" : e_tag, "flags", 32'(flags_out), 32'(e_fl));
        else if (status_restore !== e_rs) fail_line(e_tag, "restore", 32'(status_restore), 32'(e_rs));
        else if (refetch !== e_rf) fail_line(e_tag, "refetch", 32'(refetch), 32'(e_rf));
    endtask

    task automatic idle();
        in_valid = 0; dest_idx = 4'hF; set_flags = 1; op_code = 4'h0;
        @(negedge clk);
        n_vec++;
        if ({out_valid, dest_we, refetch, status_restore} !== 4'b0000)
            fail_line("R11", "idle outputs", 32'({out_valid, dest_we, refetch, status_restore}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] corner [4];
        corner[0] = 32'h0; corner[1] = 32'hFFFF_FFFF; corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        rst = 1; in_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0; shift_carry = 0;
        flags_in = 0; set_flags = 0; dest_idx = 0; saved_status = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;  // R12 reset state
        if ({out_valid, dest_we, refetch, status_restore, flags_out} !== 8'h00 || result !== 32'h0)
            fail_line("R12", "reset outputs", result, 32'h0);
        rst = 0;
        idle();
        // corner operands, every code, both carry-in values, flags requested
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int ci = 0; ci < 2; ci++)
                        apply(4'(op), corner[i], corner[j], 1'(i ^ j), {2'b01, 1'(ci), 1'b1}, 1'b1, 4'd3, 32'hA000_0000);
        // directed: SBC subtrahend reaching 2^32 (carry clear) R4
        apply(4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 4'b0000, 1, 4'd1, 0);
        // directed: program-counter destination cases R7 R8 R9
        apply(4'h4, 32'd5, 32'd7, 0, 4'b0000, 1, 4'hF, 32'h5000_0000);
        apply(4'hD, 32'd5, 32'd7, 1, 4'b1010, 0, 4'hF, 32'h5000_0000);
        apply(4'hA, 32'd5, 32'd5, 0, 4'b0000, 0, 4'hF, 32'h9000_0000);
        // directed: test code with set-flags clear still updates flags R6
        apply(4'h8, 32'hF0, 32'h0F, 1, 4'b0001, 0, 4'd2, 0);
        // directed: writing code with set-flags clear holds flags R10
        apply(4'h2, 32'd0, 32'd1, 0, 4'b0110, 0, 4'd2, 0);
        idle();
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 9) == 0) idle();
            apply(4'($urandom), $urandom, $urandom, 1'($urandom), 4'($urandom),
                  1'($urandom), ($urandom_range(0, 5) == 0) ? 4'hF : 4'($urandom), $urandom);
        end
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule